// File: doc/BRIEF.md
# Host bridge control register file

This block holds the 64-bit control and status registers of a host bridge and serves them to two requesters that share one request port. A path-select input says which requester is active. The scan path uses the request word address directly as the register index. The memory-mapped path adds a fixed offset of 0x0A to the word address, so memory-mapped word 0 lands on the base-address register. All accesses are whole 8-byte words, and data is big-endian: bit 63 of the data bus is the most significant bit of the word at the lowest byte address. The block does not swap bytes.

The fault register and the control register each have alias offsets. A write to an alias merges the data into the stored value instead of replacing it. The base-address register drives a window-enable output and a decoded base address. Only the scan path may write it. The source-compare register drives an interrupt number offset. Offsets that are not implemented read as all ones. Writes that are rejected, and accesses to unknown offsets, raise a one-cycle error pulse.

Top module: `hostbridge_regfile`

## Requirements
- R1: After reset the base-address register holds parameter BAR_INIT masked to 0x0003FFFFFFF00000 with enable bit 0 set. Every other implemented register reads zero, and err_pulse is low.
- R2: The fault register is at offset 0x00. A write to 0x00 replaces it, a write to 0x01 ANDs the data into it, and a write to 0x02 ORs the data into it.
- R3: The control register is at offset 0x0E. A write to 0x0E replaces it, a write to 0x12 sets the bits that are 1 in the data, and a write to 0x13 clears the bits that are 1 in the data.
- R4: A scan access at word address W targets offset W. A memory-mapped access at word address W (byte address 8*W) targets offset W + 0x0A.
- R5: The base-address register at offset 0x0A is written only from the scan path. A memory-mapped write to it leaves it unchanged and raises err_pulse.
- R6: A stored base address keeps only bits 0x0003FFFFFFF00000 plus enable bit 0. bar_enable shows bit 0, and bar_addr shows the masked address. The secondary base register at 0x0B keeps only bits 0x0003FFFF00000000.
- R7: A read of an offset that is not readable returns all ones and raises err_pulse. A write to an offset that is not writable changes no register and raises err_pulse. The readable offsets are 0x00, 0x06, 0x07, 0x0A, 0x0B, 0x0E, 0x0F, 0x14, 0x15 and 0x1B. The write-only aliases are 0x01, 0x02, 0x12 and 0x13.
- R8: A write to the interrupt status register at 0x15 is rejected: err_pulse rises, and the register keeps reading its previous value.
- R9: A write to the source-compare register at 0x1B keeps only bits 63:45 and 35:32. irq_offset outputs bits 63:45.
- R10: Read data and rsp_valid appear in the cycle after the request. err_pulse is high for exactly that one cycle per faulty request.
- R11: Offsets 0x06, 0x07, 0x0F and 0x14 store all 64 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_mmio | input | 1 | 1 for the memory-mapped path, 0 for the scan path |
| req_word | input | WORD_W | 8-byte word address (byte address bits above 2) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 64 | Read data |
| err_pulse | output | 1 | One-cycle pulse for a rejected or unknown access |
| bar_enable | output | 1 | Window enable from base-address bit 0 |
| bar_addr | output | 64 | Masked window base address |
| irq_offset | output | 19 | Interrupt number offset from the compare field |

## Verification
Read data, rsp_valid and err_pulse are all registered, so each is due one cycle after the request edge. Register side effects, and the bar_enable, bar_addr and irq_offset outputs, change at that same edge. Each bench task drives a request on a falling edge and samples every result on the next falling edge, just after the edge that registered it. The task then samples err_pulse again one falling edge later to confirm that the pulse lasted only one cycle. A write is checked by a read that follows it, and that read is sampled the same way.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int IDX_W     = 16;
    localparam int NSLOT     = 10;
    localparam int IRQOFF_W  = 19;

    localparam logic [IDX_W-1:0] MMIO_BASE   = 16'h000A;
    localparam logic [IDX_W-1:0] OFF_FAULT   = 16'h0000;
    localparam logic [IDX_W-1:0] OFF_F_AND   = 16'h0001;
    localparam logic [IDX_W-1:0] OFF_F_OR    = 16'h0002;
    localparam logic [IDX_W-1:0] OFF_ACT0    = 16'h0006;
    localparam logic [IDX_W-1:0] OFF_ACT1    = 16'h0007;
    localparam logic [IDX_W-1:0] OFF_BAR     = 16'h000A;
    localparam logic [IDX_W-1:0] OFF_SBAR    = 16'h000B;
    localparam logic [IDX_W-1:0] OFF_CTRL    = 16'h000E;
    localparam logic [IDX_W-1:0] OFF_SEMR    = 16'h000F;
    localparam logic [IDX_W-1:0] OFF_C_SET   = 16'h0012;
    localparam logic [IDX_W-1:0] OFF_C_CLR   = 16'h0013;
    localparam logic [IDX_W-1:0] OFF_DMA     = 16'h0014;
    localparam logic [IDX_W-1:0] OFF_ISTAT   = 16'h0015;
    localparam logic [IDX_W-1:0] OFF_CMP     = 16'h001B;

    localparam logic [63:0] BAR_ADDR_MASK = 64'h0003_FFFF_FFF0_0000;
    localparam logic [63:0] BAR_EN_BIT    = 64'h0000_0000_0000_0001;
    localparam logic [63:0] SBAR_MASK     = 64'h0003_FFFF_0000_0000;
    localparam logic [63:0] CMP_MASK      = 64'hFFFF_E00F_0000_0000;
    localparam int          CMP_SH        = 45;

    typedef enum logic [3:0] {
        S_FAULT, S_ACT0, S_ACT1, S_BAR, S_SBAR,
        S_CTRL, S_SEMR, S_DMA, S_ISTAT, S_CMP
    } slot_e;

    typedef enum logic [2:0] {
        WK_NONE, WK_STORE, WK_AND, WK_OR, WK_CLR, WK_REJECT
    } wkind_e;

    typedef struct packed {
        logic   rd_hit;
        slot_e  rd_slot;
        wkind_e wk;
        slot_e  wr_slot;
    } dec_t;

    function automatic logic [63:0] slot_wmask(slot_e s);
        case (s)
            S_BAR:   return BAR_ADDR_MASK | BAR_EN_BIT;
            S_SBAR:  return SBAR_MASK;
            S_CMP:   return CMP_MASK;
            default: return '1;
        endcase
    endfunction

    function automatic logic [63:0] slot_reset(slot_e s, logic [63:0] bar_init);
        return (s == S_BAR) ? ((bar_init & BAR_ADDR_MASK) | BAR_EN_BIT) : 64'd0;
    endfunction

    function automatic dec_t decode_idx(logic [IDX_W-1:0] idx, logic mmio);
        dec_t d;
        d.rd_hit  = 1'b0;
        d.rd_slot = S_FAULT;
        d.wk      = WK_NONE;
        d.wr_slot = S_FAULT;
        case (idx)
            OFF_FAULT: begin d.rd_hit = 1'b1; d.rd_slot = S_FAULT; d.wk = WK_STORE; d.wr_slot = S_FAULT; end
            OFF_F_AND: begin d.wk = WK_AND; d.wr_slot = S_FAULT; end
            OFF_F_OR:  begin d.wk = WK_OR;  d.wr_slot = S_FAULT; end
            OFF_ACT0:  begin d.rd_hit = 1'b1; d.rd_slot = S_ACT0; d.wk = WK_STORE; d.wr_slot = S_ACT0; end
            OFF_ACT1:  begin d.rd_hit = 1'b1; d.rd_slot = S_ACT1; d.wk = WK_STORE; d.wr_slot = S_ACT1; end
            OFF_BAR: begin
                d.rd_hit = 1'b1; d.rd_slot = S_BAR; d.wr_slot = S_BAR;
                d.wk = mmio ? WK_REJECT : WK_STORE;
            end
            OFF_SBAR:  begin d.rd_hit = 1'b1; d.rd_slot = S_SBAR; d.wk = WK_STORE; d.wr_slot = S_SBAR; end
            OFF_CTRL:  begin d.rd_hit = 1'b1; d.rd_slot = S_CTRL; d.wk = WK_STORE; d.wr_slot = S_CTRL; end
            OFF_SEMR:  begin d.rd_hit = 1'b1; d.rd_slot = S_SEMR; d.wk = WK_STORE; d.wr_slot = S_SEMR; end
            OFF_C_SET: begin d.wk = WK_OR;  d.wr_slot = S_CTRL; end
            OFF_C_CLR: begin d.wk = WK_CLR; d.wr_slot = S_CTRL; end
            OFF_DMA:   begin d.rd_hit = 1'b1; d.rd_slot = S_DMA; d.wk = WK_STORE; d.wr_slot = S_DMA; end
            OFF_ISTAT: begin d.rd_hit = 1'b1; d.rd_slot = S_ISTAT; d.wk = WK_REJECT; d.wr_slot = S_ISTAT; end
            OFF_CMP:   begin d.rd_hit = 1'b1; d.rd_slot = S_CMP; d.wk = WK_STORE; d.wr_slot = S_CMP; end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
    import hbr_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  logic              mmio,
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    localparam int EXT_W = IDX_W - WORD_W;

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx = {{EXT_W{1'b0}}, word} + (mmio ? MMIO_BASE : '0);
        dec = decode_idx(idx, mmio);
    end
endmodule

// File: rtl/hbr_regbank.sv
module hbr_regbank
    import hbr_pkg::*;
#(
    parameter logic [63:0] BAR_INIT = 64'h0003_0000_2010_0000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  wkind_e                wk,
    input  slot_e                 slot,
    input  logic [63:0]           wdata,
    output logic [NSLOT-1:0][63:0] q
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam slot_e       ME    = slot_e'(g);
        localparam logic [63:0] WMASK = slot_wmask(ME);
        localparam logic [63:0] RVAL  = slot_reset(ME, BAR_INIT);

        logic [63:0] nxt;

        always_comb begin
            nxt = q[g];
            if (we && slot == ME) begin
                case (wk)
                    WK_STORE: nxt = wdata & WMASK;
                    WK_AND:   nxt = q[g] & wdata & WMASK;
                    WK_OR:    nxt = (q[g] | wdata) & WMASK;
                    WK_CLR:   nxt = q[g] & ~wdata & WMASK;
                    default:  nxt = q[g];
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (rst) q[g] <= RVAL;
            else     q[g] <= nxt;
        end
    end

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/hostbridge_regfile.sv
module hostbridge_regfile
    import hbr_pkg::*;
#(
    parameter int          WORD_W   = 9,
    parameter logic [63:0] BAR_INIT = 64'h0003_0000_2010_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_mmio,
    input  logic [WORD_W-1:0] req_word,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              err_pulse,
    output logic              bar_enable,
    output logic [63:0]       bar_addr,
    output logic [IRQOFF_W-1:0] irq_offset
);
    dec_t                    dec;
    logic [NSLOT-1:0][63:0]  slots;
    logic                    wr_ok;
    logic                    bad_d;
    logic [63:0]             rdata_d;

    hbr_decode #(.WORD_W(WORD_W)) u_decode (
        .mmio (req_mmio),
        .word (req_word),
        .dec  (dec)
    );

    always_comb begin
        wr_ok   = req_valid && req_write && (dec.wk != WK_NONE) && (dec.wk != WK_REJECT);
        bad_d   = req_valid && (req_write ? !wr_ok : !dec.rd_hit);
        rdata_d = dec.rd_hit ? slots[dec.rd_slot] : '1;
    end

    hbr_regbank #(.BAR_INIT(BAR_INIT)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok),
        .wk    (dec.wk),
        .slot  (dec.wr_slot),
        .wdata (req_wdata),
        .q     (slots)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            err_pulse <= 1'b0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= (req_valid && !req_write) ? rdata_d : rsp_rdata;
            err_pulse <= bad_d;
        end
    end

    assign bar_enable = slots[S_BAR][0];
    assign bar_addr   = slots[S_BAR] & BAR_ADDR_MASK;
    assign irq_offset = slots[S_CMP][63:CMP_SH];

    // R5
    bar_mmio_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_mmio && req_word == '0)
        |=> (err_pulse && bar_addr == $past(bar_addr) && bar_enable == $past(bar_enable)));

    // R10
    err_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(req_valid));

    // R10
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    // R7
    unknown_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !dec.rd_hit) |=> (rsp_rdata == '1 && err_pulse));
endmodule

// File: tb/hostbridge_regfile_bench.sv
module hostbridge_regfile_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          WORD_W     = 9;
    localparam logic [63:0] BAR_INIT   = 64'h0003_0000_2010_0000;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid, req_write, req_mmio;
    logic [WORD_W-1:0] req_word;
    logic [63:0]       req_wdata;
    logic              rsp_valid;
    logic [63:0]       rsp_rdata;
    logic              err_pulse;
    logic              bar_enable;
    logic [63:0]       bar_addr;
    logic [18:0]       irq_offset;

    int checks = 0;
    int failures = 0;
    logic [63:0] got_data;
    logic        got_err, got_err_next, got_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostbridge_regfile #(.WORD_W(WORD_W), .BAR_INIT(BAR_INIT)) u_hostbridge_regfile (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_mmio(req_mmio), .req_word(req_word), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_pulse(err_pulse),
        .bar_enable(bar_enable), .bar_addr(bar_addr), .irq_offset(irq_offset)
    );

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(logic mmio, logic wr, int word, logic [63:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_mmio = mmio;
        req_word = WORD_W'(word); req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        got_data = rsp_rdata; got_err = err_pulse; got_valid = rsp_valid;
        @(negedge clk);
        got_err_next = err_pulse;
    endtask

    task automatic rd(logic mmio, int word, string tag, logic [63:0] exp, logic exp_err);
        access(mmio, 1'b0, word, '0);
        check64({tag, " data"}, got_data, exp);
        check64({tag, " err"}, 64'(got_err), 64'(exp_err));
    endtask

    task automatic wr(logic mmio, int word, logic [63:0] data, string tag, logic exp_err);
        access(mmio, 1'b1, word, data);
        check64({tag, " err"}, 64'(got_err), 64'(exp_err));
        check64({tag, " err width R10"}, 64'(got_err_next), 64'd0);
    endtask

    task automatic t_reset();
        check64("R1 bar_enable", 64'(bar_enable), 64'd1);
        check64("R1 bar_addr", bar_addr, BAR_INIT);
        check64("R1 err", 64'(err_pulse), 64'd0);
        rd(1'b0, 'h00, "R1 fault", 64'd0, 1'b0);
        rd(1'b0, 'h0E, "R1 ctrl", 64'd0, 1'b0);
        check64("R10 rsp_valid", 64'(got_valid), 64'd1);
    endtask

    task automatic t_fault();
        wr(1'b0, 'h00, 64'hF0F0_F0F0_1234_5678, "R2 store", 1'b0);
        rd(1'b0, 'h00, "R2 store", 64'hF0F0_F0F0_1234_5678, 1'b0);
        wr(1'b0, 'h01, 64'hFF00_FF00_FFFF_0000, "R2 and", 1'b0);
        rd(1'b0, 'h00, "R2 and", 64'hF000_F000_1234_0000, 1'b0);
        wr(1'b0, 'h02, 64'h0000_0001_0000_000F, "R2 or", 1'b0);
        rd(1'b0, 'h00, "R2 or", 64'hF000_F001_1234_000F, 1'b0);
    endtask

    task automatic t_ctrl();
        wr(1'b0, 'h0E, 64'h8000_0000_0000_0001, "R3 store", 1'b0);
        wr(1'b0, 'h12, 64'h4400_0000_0000_0010, "R3 set", 1'b0);
        rd(1'b0, 'h0E, "R3 set", 64'hC400_0000_0000_0011, 1'b0);
        wr(1'b0, 'h13, 64'h8000_0000_0000_0011, "R3 clear", 1'b0);
        rd(1'b0, 'h0E, "R3 clear", 64'h4400_0000_0000_0000, 1'b0);
    endtask

    task automatic t_mmio_map();
        rd(1'b1, 'h04, "R4 mmio ctrl", 64'h4400_0000_0000_0000, 1'b0);
        wr(1'b1, 'h04, 64'h0000_2000_0000_0000, "R4 mmio write", 1'b0);
        rd(1'b0, 'h0E, "R4 scan view", 64'h0000_2000_0000_0000, 1'b0);
        rd(1'b1, 'h00, "R4 mmio bar", BAR_INIT | 64'd1, 1'b0);
    endtask

    task automatic t_bar();
        wr(1'b1, 'h00, 64'h0001_0000_0000_0000, "R5 mmio bar", 1'b1);
        check64("R5 bar kept", bar_addr, BAR_INIT);
        check64("R5 en kept", 64'(bar_enable), 64'd1);
        wr(1'b0, 'h0A, 64'hFFFF_FFFF_FFFF_FFFE, "R6 bar", 1'b0);
        check64("R6 bar_addr", bar_addr, 64'h0003_FFFF_FFF0_0000);
        check64("R6 bar_enable", 64'(bar_enable), 64'd0);
        rd(1'b0, 'h0A, "R6 bar read", 64'h0003_FFFF_FFF0_0000, 1'b0);
        wr(1'b0, 'h0A, 64'h0002_0000_0030_0001, "R6 bar en", 1'b0);
        check64("R6 bar_enable on", 64'(bar_enable), 64'd1);
        check64("R6 bar_addr 2", bar_addr, 64'h0002_0000_0030_0000);
        wr(1'b0, 'h0B, '1, "R6 sbar", 1'b0);
        rd(1'b1, 'h01, "R6 sbar read", 64'h0003_FFFF_0000_0000, 1'b0);
    endtask

    task automatic t_unknown();
        rd(1'b0, 'h03, "R7 unimpl read", '1, 1'b1);
        rd(1'b0, 'h12, "R7 alias read", '1, 1'b1);
        rd(1'b1, 'h1F0, "R7 mmio far read", '1, 1'b1);
        wr(1'b0, 'h3E, 64'h1, "R7 unimpl write", 1'b1);
        rd(1'b0, 'h00, "R7 fault untouched", 64'hF000_F001_1234_000F, 1'b0);
    endtask

    task automatic t_istat();
        wr(1'b0, 'h15, '1, "R8 istat write", 1'b1);
        rd(1'b0, 'h15, "R8 istat kept", 64'd0, 1'b0);
    endtask

    task automatic t_cmp();
        wr(1'b0, 'h1B, '1, "R9 cmp", 1'b0);
        rd(1'b0, 'h1B, "R9 cmp read", 64'hFFFF_E00F_0000_0000, 1'b0);
        check64("R9 irq_offset ones", 64'(irq_offset), 64'h7FFFF);
        wr(1'b1, 'h11, 64'h0000_2000_0000_0000, "R9 cmp mmio", 1'b0);
        check64("R9 irq_offset one", 64'(irq_offset), 64'h1);
    endtask

    task automatic t_plain();
        wr(1'b0, 'h06, 64'hDEAD_BEEF_0123_4567, "R11 act0", 1'b0);
        wr(1'b0, 'h07, 64'h8765_4321_FEDC_BA98, "R11 act1", 1'b0);
        wr(1'b0, 'h0F, 64'hAAAA_5555_AAAA_5555, "R11 semr", 1'b0);
        wr(1'b0, 'h14, 64'hFFFF_FFFF_FFFF_FFFF, "R11 dma", 1'b0);
        rd(1'b0, 'h06, "R11 act0", 64'hDEAD_BEEF_0123_4567, 1'b0);
        rd(1'b0, 'h07, "R11 act1", 64'h8765_4321_FEDC_BA98, 1'b0);
        rd(1'b1, 'h05, "R11 semr", 64'hAAAA_5555_AAAA_5555, 1'b0);
        rd(1'b1, 'h0A, "R11 dma", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_mmio = 1'b0;
        req_word = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fault();
        t_ctrl();
        t_mmio_map();
        t_bar();
        t_unknown();
        t_istat();
        t_cmp();
        t_plain();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule